// File: doc/BRIEF.md
# Calendar Clock with Update Cycle

This block keeps the time of day and the calendar for a system that needs wall-clock time. It takes a 32.768 kHz tick that arrives as a one-cycle enable on the system clock. Each time a divider has counted a full second of ticks, it advances seconds, minutes, hours, day of week, day of month, month and a two-digit year. Three alarm registers hold a second, a minute and an hour. A one-cycle alarm pulse fires when a new time matches all three.

A host reaches fourteen byte registers through an address/data port. Writes are synchronous and reads are combinational. Two control bytes choose the value format (BCD or binary) and the hour form (12-hour with a PM bit, or 24-hour). The host can also inhibit updates while it loads the time, and it can hold or stop the second divider. An update-in-progress flag tells the host when reading the time is unsafe. The flag goes high a fixed number of ticks before the time changes. It stays high through a fixed update window after the change. When the window ends, the block emits a one-cycle update-done pulse.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the time reads 00:00:00, day of week 1, date 01, month 01, year 00, and all alarms read 0. Control A reads 0x20 (divider running, flag clear). Control B reads 0x02 (BCD, 24-hour, updates enabled). C reads 0x00 and D reads 0x80.
- R2: The register addresses are: seconds 0, seconds alarm 1, minutes 2, minutes alarm 3, hours 4, hours alarm 5, day of week 6, date 7, month 8, year 9, control A 10, control B 11, C 12, D 13. A value written to addresses 0–9 or 11 reads back unchanged. Addresses 14 and 15 read 0.
- R3: The divider counts ticks only while A bits 6:4 equal 010. When B bit 7 is 0, every TICKS_PER_SEC-th counted tick advances the time by one second. Seconds and minutes wrap 59→0 and carry into the next field.
- R4: B bit 2 = 1 stores every time and date field as plain binary. B bit 2 = 0 stores it as BCD, with tens in bits 7:4 and units in bits 3:0.
- R5: B bit 1 = 1 runs hours 0–23; 23 wraps to 0 and carries to the date. B bit 1 = 0 holds the hour 1–12 in bits 6:0 and PM in bit 7. The hour counts 12→1, and 11→12 toggles PM. Leaving 11 PM for 12 AM carries to the date.
- R6: The date wraps to 1 after the last day of the month. Months 4, 6, 9 and 11 have 30 days. Month 2 has 29 days when the year is divisible by 4 and 28 days otherwise. All other months have 31 days. Month 12 wraps to 1 and carries into the year. Year 99 wraps to 0. Day of week counts 1–7 and advances with the date.
- R7: A bit 7 (read-only) rises exactly UIP_LEAD ticks before the time changes. It stays high for exactly UPD_TICKS ticks after the change.
- R8: `update_done_o` is high for one cycle, in the first cycle the flag reads low again after an update.
- R9: `alarm_o` is high for one cycle, in the first cycle the new time is visible. It fires only if the new seconds, minutes and hours bytes all equal their alarm bytes.
- R10: While B bit 7 is 1, the time does not change and the flag stays low.
- R11: While A bits 6:5 are 11, the divider is held at zero. Any A bits 6:4 value other than 010 or 11x freezes the divider. In both cases no update occurs. After release from the hold, the first update comes TICKS_PER_SEC ticks later.
- R12: Writes to A bit 7, to C and to D have no effect. C always reads 0x00 and D always reads 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle enable per 32.768 kHz reference tick |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| update_done_o | output | 1 | One-cycle pulse when an update window ends |
| alarm_o | output | 1 | One-cycle pulse on an alarm match |

## Verification
The assertions take the parameters to satisfy UIP_LEAD ≥ 1, UPD_TICKS ≥ 1 and UIP_LEAD + UPD_TICKS < TICKS_PER_SEC. Under these limits the flag always covers the change edge, and update windows never overlap. They also assume the host changes a time byte only by a write, so every time check excludes cycles with a write strobe. The stimulus uses 40 ticks per second, a lead of 8 and a window of 6, with a tick on every other cycle. It loads values only while updates are inhibited and the divider is held, and it writes only legal field values, so every carry comes from the counting itself.

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int UIP_LEAD      = 8,
  parameter int UPD_TICKS     = 65
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       wr_i,
  input  logic [3:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       update_done_o,
  output logic       alarm_o
);
  localparam int DW = $clog2(TICKS_PER_SEC);
  localparam int WW = $clog2(UPD_TICKS + 1);

  logic [7:0]    tm_q [0:9];
  logic [6:0]    a_q;
  logic [7:0]    b_q;
  logic [DW-1:0] div_cnt;
  logic [WW-1:0] win_cnt;
  logic          in_upd;

  function automatic logic [6:0] to_bin(input logic [7:0] v, input logic bin);
    return bin ? v[6:0] : ({3'b0, v[7:4]} * 7'd10 + {3'b0, v[3:0]});
  endfunction

  function automatic logic [7:0] from_bin(input logic [6:0] v, input logic bin);
    return bin ? {1'b0, v} : 8'((v / 7'd10) * 8'd16 + (v % 7'd10));
  endfunction

  wire bin      = b_q[2];
  wire h24      = b_q[1];
  wire running  = a_q[6:4] == 3'b010;
  wire dv_rst   = a_q[6:5] == 2'b11;
  wire last     = div_cnt == DW'(TICKS_PER_SEC - 1);
  wire step     = tick_i && running && last && !b_q[7];
  wire uip      = (running && !b_q[7] && div_cnt >= DW'(TICKS_PER_SEC - UIP_LEAD)) || in_upd;

  logic [6:0] s, m, h, dw, dm, mo, yr, mdays;
  logic [6:0] ns, nm, nh, ndw, ndm, nmo, nyr;
  logic       pm, npm, c_min, c_hr, c_day, c_mo;
  logic [7:0] nxt_s, nxt_m, nxt_hr, hr_raw;
  logic       hit;

  always_comb begin
    s  = to_bin(tm_q[0], bin);
    m  = to_bin(tm_q[2], bin);
    h  = to_bin({1'b0, tm_q[4][6:0]}, bin);
    pm = tm_q[4][7];
    dw = to_bin(tm_q[6], bin);
    dm = to_bin(tm_q[7], bin);
    mo = to_bin(tm_q[8], bin);
    yr = to_bin(tm_q[9], bin);

    c_min = s == 7'd59;
    ns    = c_min ? 7'd0 : s + 7'd1;
    c_hr  = c_min && m == 7'd59;
    nm    = c_min ? (m == 7'd59 ? 7'd0 : m + 7'd1) : m;

    nh = h; npm = pm; c_day = 1'b0;
    if (c_hr) begin
      if (h24) begin
        if (h == 7'd23) begin nh = 7'd0; c_day = 1'b1; end
        else nh = h + 7'd1;
      end else begin
        if (h == 7'd12) nh = 7'd1;
        else if (h == 7'd11) begin nh = 7'd12; npm = ~pm; c_day = pm; end
        else nh = h + 7'd1;
      end
    end

    case (mo)
      7'd2:                   mdays = (yr[1:0] == 2'b00) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11: mdays = 7'd30;
      default:                mdays = 7'd31;
    endcase

    ndw  = c_day ? (dw >= 7'd7 ? 7'd1 : dw + 7'd1) : dw;
    c_mo = c_day && dm >= mdays;
    ndm  = c_day ? (c_mo ? 7'd1 : dm + 7'd1) : dm;
    nmo  = c_mo ? (mo >= 7'd12 ? 7'd1 : mo + 7'd1) : mo;
    nyr  = (c_mo && mo >= 7'd12) ? (yr >= 7'd99 ? 7'd0 : yr + 7'd1) : yr;

    nxt_s  = from_bin(ns, bin);
    nxt_m  = from_bin(nm, bin);
    hr_raw = from_bin(nh, bin);
    nxt_hr = {h24 ? 1'b0 : npm, hr_raw[6:0]};
    hit    = nxt_s == tm_q[1] && nxt_m == tm_q[3] && nxt_hr == tm_q[5];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 10; i++) tm_q[i] <= 8'h00;
      tm_q[6]       <= 8'h01;
      tm_q[7]       <= 8'h01;
      tm_q[8]       <= 8'h01;
      a_q           <= 7'h20;
      b_q           <= 8'h02;
      div_cnt       <= '0;
      win_cnt       <= '0;
      in_upd        <= 1'b0;
      update_done_o <= 1'b0;
      alarm_o       <= 1'b0;
    end else begin
      update_done_o <= 1'b0;
      alarm_o       <= 1'b0;
      if (dv_rst) div_cnt <= '0;
      else if (tick_i && running) div_cnt <= last ? '0 : div_cnt + 1'b1;
      if (tick_i && in_upd) begin
        if (win_cnt == '0) begin
          in_upd        <= 1'b0;
          update_done_o <= 1'b1;
        end else win_cnt <= win_cnt - 1'b1;
      end
      if (step) begin
        tm_q[0] <= nxt_s;
        tm_q[2] <= nxt_m;
        tm_q[4] <= nxt_hr;
        tm_q[6] <= from_bin(ndw, bin);
        tm_q[7] <= from_bin(ndm, bin);
        tm_q[8] <= from_bin(nmo, bin);
        tm_q[9] <= from_bin(nyr, bin);
        in_upd  <= 1'b1;
        win_cnt <= WW'(UPD_TICKS - 1);
        alarm_o <= hit;
      end
      if (wr_i) begin
        case (addr_i)
          4'd10:   a_q <= wdata_i[6:0];
          4'd11:   b_q <= wdata_i;
          4'd12, 4'd13, 4'd14, 4'd15: ;
          default: tm_q[addr_i] <= wdata_i;
        endcase
      end
    end
  end

  always_comb begin
    case (addr_i)
      4'd10:   rdata_o = {uip, a_q};
      4'd11:   rdata_o = b_q;
      4'd13:   rdata_o = 8'h80;
      4'd12, 4'd14, 4'd15: rdata_o = 8'h00;
      default: rdata_o = tm_q[addr_i];
    endcase
  end
endmodule

module rtc_calendar_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_i,
  input logic       uip,
  input logic       done,
  input logic       alarm,
  input logic [7:0] sec_q,
  input logic       set_b,
  input logic       dv_rst,
  input logic       div_zero
);
  p_time_moves_under_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_i && !uip) |=> $stable(sec_q));
  p_done_after_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!uip && $past(uip)));
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_alarm_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    alarm |=> !alarm);
  p_alarm_in_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    alarm |-> uip);
  p_set_freezes_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (set_b && !wr_i) |=> $stable(sec_q));
  p_div_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dv_rst |=> div_zero);
endmodule

bind rtc_calendar_core rtc_calendar_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_i(wr_i), .uip(uip), .done(update_done_o),
  .alarm(alarm_o), .sec_q(tm_q[0]), .set_b(b_q[7]), .dv_rst(dv_rst),
  .div_zero(div_cnt == '0)
);

// File: tb/rtc_calendar_core_tb.sv
module rtc_calendar_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TPS  = 40;
  localparam int LEAD = 8;
  localparam int UPD  = 6;

  logic       clk = 0, rst_n = 0, tick_i = 0, wr_i = 0;
  logic [3:0] addr_i = 0;
  logic [7:0] wdata_i = 0;
  logic [7:0] rdata_o;
  logic       update_done_o, alarm_o;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  initial forever begin @(negedge clk); tick_i = ~tick_i; end

  rtc_calendar_core #(.TICKS_PER_SEC(TPS), .UIP_LEAD(LEAD), .UPD_TICKS(UPD)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .update_done_o(update_done_o), .alarm_o(alarm_o));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] enc(input int v, input bit bin);
    return bin ? 8'(v) : 8'((v / 10) * 16 + v % 10);
  endfunction

  function automatic logic [7:0] enc_hr(input int hv, input bit bin, input bit h24);
    logic [7:0] t;
    int h;
    if (h24) return enc(hv, bin);
    h = hv % 12;
    if (h == 0) h = 12;
    t = enc(h, bin);
    return {hv >= 12 ? 1'b1 : 1'b0, t[6:0]};
  endfunction

  function automatic int dim(input int mo, input int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    return 30 + ((mo + mo / 8) % 2);
  endfunction

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    addr_i = 4'(a); wdata_i = d; wr_i = 1;
    @(negedge clk);
    wr_i = 0;
  endtask

  task automatic rd(input int a, output logic [7:0] v);
    @(negedge clk);
    addr_i = 4'(a);
    #1 v = rdata_o;
  endtask

  task automatic load(input int hv, input int m, input int s, input int dow, input int dom,
                      input int mo, input int yr, input bit bin, input bit h24,
                      input logic [7:0] as_, input logic [7:0] am, input logic [7:0] ah);
    logic [7:0] bm;
    bm = {5'b0, bin, h24, 1'b0};
    wr(11, bm | 8'h80);
    wr(10, 8'h60);
    wr(0, enc(s, bin));  wr(2, enc(m, bin));  wr(4, enc_hr(hv, bin, h24));
    wr(6, enc(dow, bin)); wr(7, enc(dom, bin)); wr(8, enc(mo, bin)); wr(9, enc(yr, bin));
    wr(1, as_); wr(3, am); wr(5, ah);
    wr(11, bm);
    wr(10, 8'h20);
  endtask

  task automatic wait_done();
    int c = 0;
    do begin @(negedge clk); c++; end while (!update_done_o && c < 4 * TPS);
    chk(update_done_o, "R3 update arrives", c, 2 * TPS);
  endtask

  task automatic observe(input bit want_alarm);
    logic [7:0] a, s, s0;
    int rise = -1, chg = -1, fall = -1, donec = -1, ndone = 0, alc = -1, nal = 0;
    bit prev = 0;
    rd(0, s0);
    for (int c = 0; c < 3 * TPS; c++) begin
      @(negedge clk);
      addr_i = 4'd10; #1 a = rdata_o;
      addr_i = 4'd0;  #1 s = rdata_o;
      if (a[7] && !prev && rise < 0) rise = c;
      if (!a[7] && prev && fall < 0) fall = c;
      prev = a[7];
      if (s != s0 && chg < 0) chg = c;
      if (update_done_o) begin ndone++; if (donec < 0) donec = c; end
      if (alarm_o) begin nal++; if (alc < 0) alc = c; end
    end
    chk(chg - rise == 2 * LEAD, "R7 flag lead", chg - rise, 2 * LEAD);
    chk(fall - chg == 2 * UPD, "R7 flag window", fall - chg, 2 * UPD);
    chk(donec == fall, "R8 done at flag fall", donec, fall);
    chk(ndone == 1, "R8 done width", ndone, 1);
    if (want_alarm) begin
      chk(nal == 1, "R9 alarm width", nal, 1);
      chk(alc == chg, "R9 alarm cycle", alc, chg);
    end else chk(nal == 0, "R9 no alarm on mismatch", nal, 0);
  endtask

  task automatic idle_check(input string tag, input logic [7:0] s0);
    logic [7:0] a, s;
    int seen = 0;
    for (int c = 0; c < 5 * TPS; c++) begin
      @(negedge clk);
      addr_i = 4'd10; #1 a = rdata_o;
      if (a[7] || update_done_o) seen++;
    end
    rd(0, s);
    chk(seen == 0, {tag, " flag/done quiet"}, seen, 0);
    chk(s == s0, {tag, " time frozen"}, s, s0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v, vs, vm, vh, vd, vdw, vmo, vy;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset contents
    for (int a = 0; a < 14; a++) begin
      int e;
      case (a)
        6, 7, 8: e = 1;
        10: e = 8'h20;
        11: e = 8'h02;
        13: e = 8'h80;
        default: e = 0;
      endcase
      rd(a, v);
      chk(v == 8'(e), "R1 reset value", v, e);
    end

    // R2 map and readback, R12 read-only bits
    wr(11, 8'h82);
    for (int a = 0; a < 10; a++) begin
      wr(a, 8'(a * 7 + 3));
      rd(a, v);
      chk(v == 8'(a * 7 + 3), "R2 readback", v, a * 7 + 3);
    end
    rd(11, v); chk(v == 8'h82, "R2 control B readback", v, 8'h82);
    wr(10, 8'hA0); rd(10, v); chk(v == 8'h20, "R12 A bit7 read-only", v, 8'h20);
    wr(12, 8'hFF); rd(12, v); chk(v == 8'h00, "R12 C ignores write", v, 0);
    wr(13, 8'h00); rd(13, v); chk(v == 8'h80, "R12 D ignores write", v, 8'h80);
    rd(14, v); chk(v == 8'h00, "R2 addr 14 zero", v, 0);
    rd(15, v); chk(v == 8'h00, "R2 addr 15 zero", v, 0);

    // R3/R4/R5 time-of-day sweep over all modes and hours
    for (int mode = 0; mode < 4; mode++) begin
      bit bin, h24;
      bin = mode[0]; h24 = mode[1];
      for (int hv = 0; hv < 24; hv++) begin
        for (int k = 0; k < 2; k++) begin
          int s, m, t, cy;
          s = k ? 59 : (hv * 7) % 59;
          m = k ? 59 : (hv * 11) % 60;
          load(hv, m, s, 3, 10, 5, 21, bin, h24, 8'hFF, 8'hFF, 8'hFF);
          wait_done();
          rd(0, vs); rd(2, vm); rd(4, vh); rd(7, vd); rd(6, vdw);
          t = hv * 3600 + m * 60 + s + 1;
          cy = (t >= 86400) ? 1 : 0;
          t = t % 86400;
          chk(vs == enc(t % 60, bin), "R3 R4 seconds", vs, enc(t % 60, bin));
          chk(vm == enc((t / 60) % 60, bin), "R3 R4 minutes", vm, enc((t / 60) % 60, bin));
          chk(vh == enc_hr(t / 3600, bin, h24), "R5 hours", vh, enc_hr(t / 3600, bin, h24));
          chk(vd == enc(10 + cy, bin), "R5 R6 date carry", vd, enc(10 + cy, bin));
          chk(vdw == enc(3 + cy, bin), "R6 weekday carry", vdw, enc(3 + cy, bin));
        end
      end
    end

    // R6 month-end sweep
    for (int b = 0; b < 2; b++) begin
      for (int yi = 0; yi < 4; yi++) begin
        int yr;
        yr = (yi == 0) ? 0 : (yi == 1) ? 1 : (yi == 2) ? 4 : 99;
        for (int mo = 1; mo <= 12; mo++) begin
          int dow, emo, eyr;
          dow = mo % 7 + 1;
          emo = (mo == 12) ? 1 : mo + 1;
          eyr = (mo == 12) ? (yr + 1) % 100 : yr;
          load(23, 59, 59, dow, dim(mo, yr), mo, yr, b[0], 1'b1, 8'hFF, 8'hFF, 8'hFF);
          wait_done();
          rd(7, vd); rd(8, vmo); rd(9, vy); rd(6, vdw);
          chk(vd == enc(1, b[0]), "R6 date wraps", vd, enc(1, b[0]));
          chk(vmo == enc(emo, b[0]), "R6 month", vmo, enc(emo, b[0]));
          chk(vy == enc(eyr, b[0]), "R6 year", vy, enc(eyr, b[0]));
          chk(vdw == enc(dow % 7 + 1, b[0]), "R6 weekday", vdw, enc(dow % 7 + 1, b[0]));
        end
      end
    end
    load(23, 59, 59, 2, 28, 2, 8, 1'b0, 1'b1, 8'hFF, 8'hFF, 8'hFF);
    wait_done();
    rd(7, vd); chk(vd == 8'h29, "R6 leap day", vd, 8'h29);

    // R7/R8/R9 flag timing and alarm
    load(10, 20, 30, 1, 1, 1, 0, 1'b1, 1'b1, 8'd31, 8'd20, 8'd10);
    observe(1'b1);
    load(10, 20, 30, 1, 1, 1, 0, 1'b1, 1'b1, 8'd31, 8'd20, 8'd11);
    observe(1'b0);

    // R10 set bit inhibits
    load(5, 6, 7, 1, 1, 1, 0, 1'b1, 1'b1, 8'hFF, 8'hFF, 8'hFF);
    wr(11, 8'h86);
    idle_check("R10", 8'd7);
    wr(11, 8'h06);
    wait_done();
    rd(0, vs); chk(vs == 8'd8, "R10 resumes", vs, 8);

    // R11 divider hold and freeze, then timed release
    wr(10, 8'h60);
    idle_check("R11 hold", 8'd8);
    wr(10, 8'h00);
    idle_check("R11 freeze", 8'd8);
    wr(10, 8'h20);
    begin
      int c = 0;
      do begin @(negedge clk); c++; addr_i = 4'd0; #1 vs = rdata_o; end
      while (vs == 8'd8 && c < 4 * TPS);
      chk(c >= 2 * TPS - 1 && c <= 2 * TPS, "R11 full second after release", c, 2 * TPS);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule